// File: doc/BRIEF.md
# Shared-Term Carry Select Adder

This block adds two unsigned WIDTH-bit operands and a carry input. It is purely combinational. It produces a WIDTH-bit sum and a carry output. The operand bits are grouped into blocks of BLK bits. The lowest block is a plain ripple chain fed by the carry input. Every higher block works out two candidate results in advance: one assumes its incoming carry is 0, the other assumes it is 1. When the real carry arrives from the block below, a multiplexer picks one of the two. The carry then crosses each block in one multiplexer delay, not a full ripple.

The two candidate chains in a block are not two copies of an adder; they share their per-bit terms. Each bit has one exclusive-OR. Its inverse is the sum bit for the case where the incoming carry is set. Each bit also has one AND and one OR, and both candidate carry chains use these as generate and propagate terms. WIDTH need not be a multiple of BLK; the top block is then narrower.

The block has no clock, so the style's valid/ready handshake does not apply. It is used wherever a wide addition must settle within one cycle.

Top module: `shared_csel_adder`

## Requirements
- R1: {carry_out, sum} equals op_a + op_b + carry_in, computed as a WIDTH+1 bit unsigned value, for every input combination.
- R2: With op_a all ones, op_b zero and carry_in 1, sum is zero and carry_out is 1. The carry passes through every block boundary.
- R3: carry_out is 1 exactly when the unsigned sum exceeds 2^WIDTH - 1, and 0 otherwise.
- R4: The carry into each higher block is the true carry produced by all lower bits. A carry generated inside one block is selected into the next block.
- R5: The lowest block takes carry_in directly, so with both operands zero, carry_in 1 gives sum 1 and carry_out 0.
- R6: With both operands zero and carry_in 0, sum and carry_out are zero.
- R7: A WIDTH that is not a multiple of BLK gives a correct result. The top block is then narrower than BLK.
- R8: Raising carry_in from 0 to 1, with the operands held, raises {carry_out, sum} by exactly one. Inside each block, the carry-in-1 candidate is the carry-in-0 candidate plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
An 8-bit adder with 4-bit blocks is driven through every operand pair, with both carry-in values. This leaves no selection path untried. A 32-bit adder gets seeded random operands, which test long mixes of generate and propagate. A 10-bit adder with 3-bit blocks gets random operands to catch errors in slicing the narrow top block. Directed cases cover: carries rippling the full width, a carry made exactly at a block boundary, overflow against near-overflow, and the same operands with the carry input toggled. Together they separate a wrong candidate choice from a wrong candidate value.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Number of blocks needed to cover w bits with blocks of b bits.
  function automatic int num_blocks(input int w, input int b);
    return (w + b - 1) / b;
  endfunction

  // Width of block k; the top block may be narrower.
  function automatic int blk_w(input int k, input int w, input int b);
    int rem;
    rem = w - k * b;
    return (rem < b) ? rem : b;
  endfunction

endpackage

// File: rtl/csel_ripple.sv
// Lowest block: a single ripple chain driven by the true carry input.
module csel_ripple #(
  parameter int BW = 4
) (
  input  logic [BW-1:0] a,
  input  logic [BW-1:0] b,
  input  logic          cin,
  output logic [BW-1:0] s,
  output logic          co
);

  logic [BW-1:0] x, g, p;
  logic [BW:0]   c;

  assign x    = a ^ b;
  assign g    = a & b;
  assign p    = a | b;
  assign c[0] = cin;

  for (genvar i = 0; i < BW; i++) begin : g_bit
    assign s[i]   = x[i] ^ c[i];
    assign c[i+1] = g[i] | (p[i] & c[i]);
  end

  assign co = c[BW];

endmodule

// File: rtl/csel_slice.sv
// Higher block: two candidate results built from one shared set of
// per-bit terms (xor, its inverse, and, or).
module csel_slice #(
  parameter int BW = 4
) (
  input  logic [BW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [BW-1:0] s0,
  output logic [BW-1:0] s1,
  output logic          co0,
  output logic          co1
);

  logic [BW-1:0] x, xn, g, p;
  logic [BW:0]   c0, c1;

  assign x  = a ^ b;
  assign xn = ~x;
  assign g  = a & b;
  assign p  = a | b;

  // Assumed incoming carries; bit 0 therefore reduces to x / xn and g / p.
  assign c0[0] = 1'b0;
  assign c1[0] = 1'b1;

  for (genvar i = 0; i < BW; i++) begin : g_bit
    assign s0[i]   = c0[i] ? xn[i] : x[i];
    assign s1[i]   = c1[i] ? xn[i] : x[i];
    assign c0[i+1] = g[i] | (p[i] & c0[i]);
    assign c1[i+1] = g[i] | (p[i] & c1[i]);
  end

  assign co0 = c0[BW];
  assign co1 = c1[BW];

  always_comb begin
    if (!$isunknown({a, b})) begin
      // R8: the carry-in-1 candidate sits exactly one above the carry-in-0 one
      assert_cand_step_R8: assert ({co1, s1} == {co0, s0} + (BW+1)'(1))
        else $error("candidate pair not one apart");
      // R8: a carry out with carry-in 0 implies a carry out with carry-in 1
      assert_carry_order_R8: assert (!co0 || co1)
        else $error("candidate carries out of order");
    end
  end

endmodule

// File: rtl/csel_pick.sv
// Selects one candidate pair by the true incoming carry.
module csel_pick #(
  parameter int BW = 4
) (
  input  logic          sel,
  input  logic [BW-1:0] s0,
  input  logic [BW-1:0] s1,
  input  logic          co0,
  input  logic          co1,
  output logic [BW-1:0] s,
  output logic          co
);

  assign s  = sel ? s1 : s0;
  assign co = sel ? co1 : co0;

endmodule

// File: rtl/shared_csel_adder.sv
module shared_csel_adder
  import csel_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int BLK   = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);

  localparam int NBLK = num_blocks(WIDTH, BLK);

  logic [NBLK:0] bc;  // true carry into each block
  assign bc[0] = carry_in;

  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    localparam int BW = blk_w(k, WIDTH, BLK);
    localparam int LO = k * BLK;

    if (k == 0) begin : g_first
      csel_ripple #(.BW(BW)) u_first (
        .a  (op_a[LO +: BW]),
        .b  (op_b[LO +: BW]),
        .cin(bc[0]),
        .s  (sum[LO +: BW]),
        .co (bc[1])
      );
    end else begin : g_sel
      logic [BW-1:0] s0, s1;
      logic          co0, co1;

      csel_slice #(.BW(BW)) u_slice (
        .a  (op_a[LO +: BW]),
        .b  (op_b[LO +: BW]),
        .s0 (s0),
        .s1 (s1),
        .co0(co0),
        .co1(co1)
      );

      csel_pick #(.BW(BW)) u_pick (
        .sel(bc[k]),
        .s0 (s0),
        .s1 (s1),
        .co0(co0),
        .co1(co1),
        .s  (sum[LO +: BW]),
        .co (bc[k+1])
      );
    end

    // Arithmetic reference for this block's carry out
    logic [BW:0] blk_ref;
    assign blk_ref = {1'b0, op_a[LO +: BW]} + {1'b0, op_b[LO +: BW]}
                   + {{BW{1'b0}}, bc[k]};

    always_comb begin
      if (!$isunknown({op_a[LO +: BW], op_b[LO +: BW], bc[k]})) begin
        // R4: carry passed upward equals the true arithmetic carry of this block
        assert_blk_carry_R4: assert (bc[k+1] == blk_ref[BW])
          else $error("block carry mismatch");
      end
    end
  end

  assign carry_out = bc[NBLK];

  logic [WIDTH:0] total_ref;
  assign total_ref = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    if (!$isunknown({op_a, op_b, carry_in})) begin
      // R1: full result matches the arithmetic sum
      assert_sum_exact_R1: assert ({carry_out, sum} == total_ref)
        else $error("sum mismatch");
    end
  end

endmodule

// File: tb/test_shared_csel_adder.sv
module test_shared_csel_adder;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 60000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int wdog = 0;

  // 8-bit, 4-bit blocks
  logic [7:0]  a8, b8, s8;
  logic        ci8, co8;
  // 32-bit, 4-bit blocks
  logic [31:0] a32, b32, s32;
  logic        ci32, co32;
  // 10-bit, 3-bit blocks (uneven top block)
  logic [9:0]  a10, b10, s10;
  logic        ci10, co10;

  shared_csel_adder #(.WIDTH(8), .BLK(4)) i_shared_csel_adder (
    .op_a(a8), .op_b(b8), .carry_in(ci8), .sum(s8), .carry_out(co8));

  shared_csel_adder #(.WIDTH(32), .BLK(4)) i_shared_csel_adder_w32 (
    .op_a(a32), .op_b(b32), .carry_in(ci32), .sum(s32), .carry_out(co32));

  shared_csel_adder #(.WIDTH(10), .BLK(3)) i_shared_csel_adder_w10 (
    .op_a(a10), .op_b(b10), .carry_in(ci10), .sum(s10), .carry_out(co10));

  function automatic logic [32:0] ref_add(input logic [31:0] a, input logic [31:0] b,
                                          input logic c, input int w);
    logic [32:0] t;
    logic [32:0] mask;
    t = {1'b0, a} + {1'b0, b} + {32'd0, c};
    mask = (33'd1 << (w + 1)) - 33'd1;
    return t & mask;
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do8(input string req, input logic [7:0] a, input logic [7:0] b, input logic c);
    a8 = a; b8 = b; ci8 = c;
    #1;
    check(req, {24'd0, co8, s8}, ref_add({24'd0, a}, {24'd0, b}, c, 8));
  endtask

  task automatic do32(input string req, input logic [31:0] a, input logic [31:0] b, input logic c);
    a32 = a; b32 = b; ci32 = c;
    #1;
    check(req, {co32, s32}, ref_add(a, b, c, 32));
  endtask

  task automatic do10(input string req, input logic [9:0] a, input logic [9:0] b, input logic c);
    a10 = a; b10 = b; ci10 = c;
    #1;
    check(req, {22'd0, co10, s10}, ref_add({22'd0, a}, {22'd0, b}, c, 10));
  endtask

  always @(posedge clk) begin
    if (!done) begin
      wdog <= wdog + 1;
      if (wdog == WDOG_CYCLES) begin
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected fewer than %0d", wdog, WDOG_CYCLES);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [32:0] lo, hi;
    void'($urandom(32'h5EED_0C5A));
    a8 = '0; b8 = '0; ci8 = 1'b0;
    a32 = '0; b32 = '0; ci32 = 1'b0;
    a10 = '0; b10 = '0; ci10 = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: zero in, zero out on all three widths
    do8("R6", 8'h00, 8'h00, 1'b0);
    do32("R6", 32'h0, 32'h0, 1'b0);
    do10("R6", 10'h0, 10'h0, 1'b0);

    // R5: carry_in alone reaches bit 0
    do8("R5", 8'h00, 8'h00, 1'b1);
    do32("R5", 32'h0, 32'h0, 1'b1);

    // R2: carry ripples across every block
    do8("R2", 8'hFF, 8'h00, 1'b1);
    do32("R2", 32'hFFFF_FFFF, 32'h0, 1'b1);
    do10("R2", 10'h3FF, 10'h0, 1'b1);

    // R3: overflow versus largest non-overflowing sum
    do8("R3", 8'h80, 8'h80, 1'b0);
    do8("R3", 8'h7F, 8'h80, 1'b0);
    do32("R3", 32'h8000_0000, 32'h8000_0000, 1'b0);
    do32("R3", 32'h7FFF_FFFF, 32'h8000_0000, 1'b0);

    // R4: carry made exactly at a block boundary
    do8("R4", 8'h0F, 8'h01, 1'b0);
    do32("R4", 32'h0FFF_FFFF, 32'h0000_0001, 1'b0);
    do32("R4", 32'h00F0_F0F0, 32'h0010_1010, 1'b0);
    do10("R4", 10'h007, 10'h001, 1'b0);

    // R8: toggling carry_in with operands held adds exactly one
    a32 = 32'h1234_FFFF; b32 = 32'h0000_0000; ci32 = 1'b0; #1;
    lo = {co32, s32};
    ci32 = 1'b1; #1;
    hi = {co32, s32};
    check("R8", hi, lo + 33'd1);
    a8 = 8'hFF; b8 = 8'hFF; ci8 = 1'b0; #1;
    lo = {24'd0, co8, s8};
    ci8 = 1'b1; #1;
    hi = {24'd0, co8, s8};
    check("R8", hi, lo + 33'd1);

    // R1: exhaustive at 8 bits, both carry values
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        do8("R1", 8'(i), 8'(j), 1'b0);
        do8("R1", 8'(i), 8'(j), 1'b1);
      end
    end

    // R1: seeded random at 32 bits
    for (int n = 0; n < 4000; n++) begin
      do32("R1", $urandom, $urandom, 1'($urandom));
    end

    // R7: uneven top block, random plus full carry chain
    for (int n = 0; n < 3000; n++) begin
      do10("R7", 10'($urandom), 10'($urandom), 1'($urandom));
    end
    do10("R7", 10'h3FF, 10'h3FF, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule